// File: doc/BRIEF.md
# Peripheral Bus Stall Guard

This block sits on a simple request/ready peripheral bus between the masters and a group of low-power slaves. A master raises a request together with an address and its master ID, and keeps all three steady until it sees ready. While an access waits, the guard counts cycles of the single clock. If the slave never answers within a programmable threshold, the guard completes the access itself. It drives ready to the master for one cycle, together with an error flag, so the master is released and can tell the result from a real response.

On such a forced completion the guard records the address and master ID of the stalled access and raises a sticky interrupt. A small register port lets software set the threshold and the protection enable, read the captured address and ID, and clear the interrupt. While the interrupt is pending, later timeouts do not overwrite the capture, so the first fault is preserved. Arbitration, slave decoding and clock crossing belong to other blocks.

Top module: `bus_stall_guard`

## Requirements
- R1: After reset the threshold is 65535, protection is enabled, the interrupt is clear and both capture registers read 0.
- R2: The master-side ready equals the slave's ready in every cycle except a forced cycle, and the error flag is 0 whenever the slave's ready completes the access.
- R3: An access that starts with the threshold set to T and never receives slave ready is given a forced ready in the (T+2)-th cycle of the request, counting the first cycle in which the request is high as cycle 1. T = 0 gives the forced ready in cycle 2.
- R4: The wait count restarts from 0 when the slave's ready completes an access, so a new access that follows at once gets the full window of R3.
- R5: A forced completion drives ready and the error flag high together for exactly one cycle. The guard then returns to idle.
- R6: With protection disabled, no forced ready, error flag or interrupt is ever produced, however long an access waits.
- R7: On a timeout with no interrupt pending, the access's 32-bit address is captured (read at select 1) and its 7-bit master ID is captured (read at select 2, zero-extended in bits 6:0).
- R8: The interrupt stays set until cleared. While it is set, further timeouts leave both captures unchanged.
- R9: Writing select 0 with bit 17 set clears a pending interrupt. Bit 17 always reads back as 0.
- R10: If a clear write and a timeout fall on the same clock edge, the interrupt stays set.
- R11: Select 0 holds the threshold in bits 15:0 (read/write), protection enable in bit 16 (read/write), the write-only clear in bit 17, and the interrupt status in bit 18 (read-only). Select 3 reads 0. Reads are combinational from the select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, also the timeout counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_req | input | 1 | Master request, held until ready |
| m_addr | input | 32 | Address of the pending access |
| m_id | input | 7 | ID of the master issuing the access |
| s_ready | input | 1 | Slave's own ready |
| m_ready | output | 1 | Ready seen by the master (slave or forced) |
| m_err | output | 1 | High with a forced ready |
| irq | output | 1 | Sticky timeout interrupt |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |

## Verification
Several properties are checked on every cycle. A ready without the slave's ready always carries the error flag and a pending interrupt. The error flag never lasts two cycles and never appears without protection enabled in the cycle before. A clear with no coincident timeout always drops the interrupt. The captured address never changes while the interrupt stays pending, and the clear bit never reads back as 1. The exact cycle of the forced ready, the restart of the count after a real ready, the captured values, and the clear-against-timeout race can only be shown by the bench's directed scenarios. Those scenarios count clock edges from the start of a request.

// File: rtl/stall_pkg.sv
// Package: shared types for the bus stall guard.
// Assumes: included before any stall_* module in compile order.
package stall_pkg;
    // Control state of the stall guard.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_FORCE = 2'd2
    } stall_state_e;

    // Register select codes.
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_ID   = 2'd2;
endpackage

// File: rtl/stall_counter.sv
// Module: stall_counter
// Counts wait cycles of the pending access. It saturates at its maximum value.
// Assumes: cnt_clr takes priority over cnt_en.
module stall_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             cnt_clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Wait-cycle counter with clear and saturation.
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_clr) begin
            cnt <= '0;
        end else if (cnt_en && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/stall_fsm.sv
// Module: stall_fsm
// Tracks the access state and decides a timeout. It forces completion for one
// cycle, captures the first fault and keeps the sticky interrupt.
// Assumes: the master holds m_req, m_addr and m_id steady until it sees ready.
module stall_fsm
    import stall_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 32,
    parameter int ID_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_req,
    input  logic              s_ready,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [ID_W-1:0]   m_id,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  thresh,
    input  logic              prot_en,
    input  logic              clr_pulse,
    output logic              force_rdy,
    output logic              cnt_en,
    output logic              cnt_clr,
    output logic              irq,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [ID_W-1:0]   cap_id
);
    stall_state_e state, state_nxt;
    logic         timeout;

    // Timeout decision and counter control.
    always_comb begin
        timeout = prot_en && m_req && !s_ready && (cnt == thresh)
                  && (state != ST_FORCE);
        cnt_en  = m_req && !s_ready;
        cnt_clr = !m_req || s_ready || (state == ST_FORCE) || timeout;
    end

    // Next-state selection.
    always_comb begin
        if (state == ST_FORCE) begin
            state_nxt = ST_IDLE;
        end else if (timeout) begin
            state_nxt = ST_FORCE;
        end else if (m_req && !s_ready) begin
            state_nxt = ST_WAIT;
        end else begin
            state_nxt = ST_IDLE;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    assign force_rdy = (state == ST_FORCE);

    // Sticky interrupt; a timeout outranks a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq <= 1'b0;
        else if (timeout)   irq <= 1'b1;
        else if (clr_pulse) irq <= 1'b0;
    end

    // First-fault capture of address and master ID.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_id   <= '0;
        end else if (timeout && !irq) begin
            cap_addr <= m_addr;
            cap_id   <= m_id;
        end
    end
endmodule

// File: rtl/stall_regs.sv
// Module: stall_regs
// Register port: threshold, protection enable, a self-clearing clear strobe,
// and read access to the interrupt status and the captures.
// Assumes: CNT_W + 3 <= ADDR_W; the register width equals ADDR_W.
module stall_regs
    import stall_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 32,
    parameter int ID_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              irq,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [ID_W-1:0]   cap_id,
    output logic [CNT_W-1:0]  thresh,
    output logic              prot_en,
    output logic              clr_pulse,
    output logic [ADDR_W-1:0] reg_rdata
);
    localparam int EN_BIT  = CNT_W;
    localparam int CLR_BIT = CNT_W + 1;
    localparam int PAD_W   = ADDR_W - CNT_W - 3;

    logic ctrl_wr;
    logic unused_wbits;

    assign ctrl_wr      = reg_we && (reg_sel == SEL_CTRL);
    assign clr_pulse    = ctrl_wr && reg_wdata[CLR_BIT];
    assign unused_wbits = ^reg_wdata[ADDR_W-1:CLR_BIT+1];

    // Threshold and enable storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thresh  <= '1;
            prot_en <= 1'b1;
        end else if (ctrl_wr) begin
            thresh  <= reg_wdata[CNT_W-1:0];
            prot_en <= reg_wdata[EN_BIT];
        end
    end

    // Read multiplexer.
    always_comb begin
        case (reg_sel)
            SEL_CTRL: reg_rdata = {{PAD_W{1'b0}}, irq, 1'b0, prot_en, thresh};
            SEL_ADDR: reg_rdata = cap_addr;
            SEL_ID:   reg_rdata = {{(ADDR_W-ID_W){1'b0}}, cap_id};
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/bus_stall_guard.sv
// Module: bus_stall_guard (top)
// Guards a request/ready peripheral bus against slaves that never answer.
// Assumes: one clock for bus and counting; masters hold a request until ready.
module bus_stall_guard #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 32,
    parameter int ID_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_req,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [ID_W-1:0]   m_id,
    input  logic              s_ready,
    output logic              m_ready,
    output logic              m_err,
    output logic              irq,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata
);
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  thresh;
    logic              prot_en;
    logic              clr_pulse;
    logic              force_rdy;
    logic              cnt_en;
    logic              cnt_clr;
    logic [ADDR_W-1:0] cap_addr;
    logic [ID_W-1:0]   cap_id;

    stall_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_clr(cnt_clr), .cnt(cnt)
    );

    stall_fsm #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .m_req(m_req), .s_ready(s_ready),
        .m_addr(m_addr), .m_id(m_id), .cnt(cnt), .thresh(thresh),
        .prot_en(prot_en), .clr_pulse(clr_pulse), .force_rdy(force_rdy),
        .cnt_en(cnt_en), .cnt_clr(cnt_clr), .irq(irq),
        .cap_addr(cap_addr), .cap_id(cap_id)
    );

    stall_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .irq(irq), .cap_addr(cap_addr), .cap_id(cap_id),
        .thresh(thresh), .prot_en(prot_en), .clr_pulse(clr_pulse),
        .reg_rdata(reg_rdata)
    );

    // Master-side handshake: the slave's ready or a forced completion.
    assign m_ready = s_ready || force_rdy;
    assign m_err   = force_rdy;
endmodule

// File: rtl/stall_guard_chk.sv
// Module: stall_guard_chk
// Cycle-by-cycle properties of bus_stall_guard, attached by bind.
// Assumes: rst_n is synchronous active-low.
module stall_guard_chk #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_ready,
    input logic              m_ready,
    input logic              m_err,
    input logic              irq,
    input logic              reg_we,
    input logic [1:0]        reg_sel,
    input logic [ADDR_W-1:0] reg_wdata,
    input logic [ADDR_W-1:0] reg_rdata,
    input logic              prot_en,
    input logic [ADDR_W-1:0] cap_addr
);
    // R2
    ready_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_ready && !s_ready) |-> m_err);

    // R5
    err_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_err |=> !m_err);

    // R5
    err_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_err |-> m_ready);

    // R6
    force_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_err |-> $past(prot_en));

    // R10
    timeout_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_err |-> irq);

    // R9
    clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_we && reg_sel == 2'd0 && reg_wdata[CNT_W+1]) && !m_err) |-> !irq);

    // R8
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(irq)) |-> $stable(cap_addr));

    // R9
    clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd0) |-> !reg_rdata[CNT_W+1]);
endmodule

bind bus_stall_guard stall_guard_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .m_ready(m_ready),
    .m_err(m_err), .irq(irq), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prot_en(prot_en),
    .cap_addr(cap_addr)
);

// File: tb/sim_bus_stall_guard.sv
module sim_bus_stall_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_req = 1'b0;
    logic [31:0] m_addr = '0;
    logic [6:0]  m_id = '0;
    logic        s_ready = 1'b0;
    logic        m_ready, m_err, irq;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    bus_stall_guard u0 (
        .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_addr(m_addr), .m_id(m_id),
        .s_ready(s_ready), .m_ready(m_ready), .m_err(m_err), .irq(irq),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        tick();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] data);
        reg_sel = sel;
        #1;
        data = reg_rdata;
    endtask

    // Returns the number of edges until m_ready is seen (0 if never).
    task automatic wait_ready(input int limit, output int k);
        k = 0;
        for (int i = 1; i <= limit; i++) begin
            tick();
            if (m_ready) begin
                k = i;
                break;
            end
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); check("R1 ctrl reset", d, 32'h0001_FFFF);
        rd(2'd1, d); check("R1 addr reset", d, 32'h0);
        rd(2'd2, d); check("R1 id reset", d, 32'h0);
        check("R1 irq reset", {31'b0, irq}, 32'd0);
        rd(2'd3, d); check("R11 sel3 zero", d, 32'h0);
    endtask

    task automatic t_passthru();
        int k;
        m_addr = 32'h1000_0040; m_id = 7'h03; m_req = 1'b1; s_ready = 1'b0;
        tick(); tick();
        check("R2 wait no ready", {30'b0, m_ready, m_err}, 32'd0);
        s_ready = 1'b1; #1;
        check("R2 ready passes", {30'b0, m_ready, m_err}, 32'd2);
        tick();
        m_req = 1'b0; s_ready = 1'b0; #1;
        check("R2 ready follows slave", {31'b0, m_ready}, 32'd0);
        k = 0;
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr(2'd0, 32'h0001_0004);
        rd(2'd0, d); check("R11 ctrl readback", d, 32'h0001_0004);
    endtask

    task automatic t_timeout();
        int k;
        logic [31:0] d;
        m_addr = 32'hA1A1_0010; m_id = 7'h15; m_req = 1'b1; s_ready = 1'b0;
        wait_ready(50, k);
        check("R3 force cycle T=4", k, 5);
        check("R5 err with force", {31'b0, m_err}, 32'd1);
        m_req = 1'b0;
        tick();
        check("R5 one cycle only", {30'b0, m_ready, m_err}, 32'd0);
        check("R7 irq set", {31'b0, irq}, 32'd1);
        rd(2'd1, d); check("R7 captured addr", d, 32'hA1A1_0010);
        rd(2'd2, d); check("R7 captured id", d, 32'h15);
    endtask

    task automatic t_sticky();
        int k;
        logic [31:0] d;
        m_addr = 32'hB2B2_0020; m_id = 7'h2A; m_req = 1'b1;
        wait_ready(50, k);
        check("R8 second timeout forced", k, 5);
        m_req = 1'b0;
        tick();
        rd(2'd1, d); check("R8 addr kept", d, 32'hA1A1_0010);
        rd(2'd2, d); check("R8 id kept", d, 32'h15);
        rd(2'd0, d); check("R8 irq still set", d, 32'h0005_0004);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(2'd0, 32'h0003_0004);
        check("R9 irq cleared", {31'b0, irq}, 32'd0);
        rd(2'd0, d); check("R9 clear bit reads 0", d, 32'h0001_0004);
    endtask

    task automatic t_restart();
        int k;
        logic [31:0] d;
        m_addr = 32'hC3C3_0030; m_id = 7'h11; m_req = 1'b1; s_ready = 1'b0;
        tick(); tick(); tick();
        s_ready = 1'b1;
        tick();
        s_ready = 1'b0; m_addr = 32'hD4D4_0044; m_id = 7'h22;
        wait_ready(50, k);
        check("R4 full window after slave ready", k, 5);
        m_req = 1'b0;
        tick();
        rd(2'd1, d); check("R7 captured new addr", d, 32'hD4D4_0044);
        wr(2'd0, 32'h0003_0004);
    endtask

    task automatic t_disable();
        int seen = 0;
        wr(2'd0, 32'h0000_0004);
        m_addr = 32'hE5E5_0050; m_req = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (m_ready || m_err) seen++;
        end
        check("R6 no force when disabled", seen, 0);
        m_req = 1'b0;
        tick();
        check("R6 no irq when disabled", {31'b0, irq}, 32'd0);
        wr(2'd0, 32'h0001_0004);
    endtask

    task automatic t_race();
        int k;
        logic [31:0] d;
        m_addr = 32'hF6F6_0060; m_id = 7'h33; m_req = 1'b1;
        wait_ready(50, k);
        m_req = 1'b0;
        tick();
        check("R10 setup irq", {31'b0, irq}, 32'd1);
        m_addr = 32'h0707_0070; m_id = 7'h44; m_req = 1'b1;
        tick(); tick(); tick(); tick();
        check("R10 not yet forced", {31'b0, m_ready}, 32'd0);
        reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 32'h0003_0004;
        tick();
        reg_we = 1'b0; reg_wdata = '0;
        check("R10 forced on race edge", {31'b0, m_ready}, 32'd1);
        check("R10 irq survives clear", {31'b0, irq}, 32'd1);
        m_req = 1'b0;
        tick();
        rd(2'd1, d); check("R10 first fault kept", d, 32'hF6F6_0060);
        wr(2'd0, 32'h0003_0004);
    endtask

    task automatic t_thresh0();
        int k;
        wr(2'd0, 32'h0001_0000);
        m_addr = 32'h0808_0080; m_req = 1'b1;
        wait_ready(50, k);
        check("R3 force cycle T=0", k, 1);
        m_req = 1'b0;
        tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_passthru();
        t_readback();
        t_timeout();
        t_sticky();
        t_clear();
        t_restart();
        t_disable();
        t_race();
        t_thresh0();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule